// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block sits passively on an SDRAM command bus and samples it on every rising clock edge. It turns the chip select, row strobe, column strobe and write enable levels into a named command. It follows the life of one bank through a small state machine, and it raises a one-cycle flag whenever a command arrives that the bank's current state forbids.

The transient states are write recovery, write recovery that ends in an automatic precharge, precharging, refresh and mode-register setup. Each has its own rule set, which says which commands pass as no-ops, which ones start a new access, and which ones are illegal. A timed state is left after a parameterised number of clock cycles.

Commands aimed at a bank other than the tracked one leave the tracked bank alone. A low clock enable while the bank is idle parks the monitor in power-down.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Every edge is decoded and reported on `cmdOut` after that edge. With the chip select high the command is deselect (code 0). With it low, the {row, column, write} strobe levels map as 111 no-op (1), 110 burst stop (2), 101 read (3), 100 write (4), 011 activate (5), 010 precharge (6), 001 refresh (7) and 000 mode set (8).
- R2: After reset, `stateOut` is idle and `illegal` is 0. The state codes are 0 idle, 1 row open, 2 write recovery, 3 write recovery with auto precharge, 4 precharging, 5 refreshing, 6 mode-set access and 7 power-down.
- R3: In idle with clock enable low, the next state is power-down. With clock enable high: activate opens the row, refresh enters refreshing, mode set enters mode-set access, and deselect, no-op, burst stop and precharge are no-ops. Read and write to the tracked bank are illegal.
- R4: In power-down the command pins are ignored and never flagged. The first edge with clock enable high returns the monitor to idle.
- R5: In row open, a read with A10 high goes to precharging, while a read with A10 low stays in row open. A write goes to write recovery, or to its auto-precharge variant when A10 is high. A precharge to the tracked bank, or any precharge with A10 high, goes to precharging. Activate, refresh and mode set are illegal.
- R6: In write recovery, deselect, no-op and burst stop are no-ops. A read returns to row open (A10 low) or goes to precharging (A10 high). A write restarts recovery in the variant chosen by A10. Activate, any precharge to the tracked bank or with A10 high, refresh and mode set are illegal. When the recovery time ends, the state becomes row open.
- R7: In write recovery with auto precharge, only deselect, no-op, burst stop and other-bank commands are accepted, and every other command is illegal. When the recovery time ends, the state becomes precharging.
- R8: In refreshing, only deselect, no-op and burst stop are accepted, whatever the bank address. The state reaches idle after the refresh time.
- R9: In mode-set access, only deselect and no-op are accepted, and burst stop is illegal. The state reaches idle after the mode-set time.
- R10: In precharging, deselect, no-op, burst stop and any precharge are no-ops. A read, write or activate to the tracked bank is illegal, and so are refresh and mode set. The state reaches idle after the precharge time.
- R11: Each timed state has a count T (TDPL, TRC, TRSC, TRP). Every edge that carries a legal no-op advances the count by one, and the state is left on the T-th such edge after entry.
- R12: An illegal command sets `illegal` for exactly the cycle after its edge. It changes neither the state nor the remaining time count.
- R13: In idle, row open, both recovery states and precharging, a read, a write, an activate, or a precharge with A10 low is treated as a no-op when `ba` differs from TRACK_BANK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| ba | input | BA_W | Bank address |
| cke | input | 1 | Clock enable |
| cmdOut | output | 4 | Decoded command of the last edge |
| stateOut | output | 3 | Bank state after the last edge |
| illegal | output | 1 | Last command was illegal in its state |

## Verification
On every cycle, the embedded properties check four things: an illegal command never moves the state or the timer; power-down is entered only from idle and produces no flags; refresh and mode-set access always drain into idle; and the auto-precharge recovery always drains into precharging. The remaining behaviour can only be shown by the bench's sweep, which applies every command, with both A10 values and both bank matches, in each of the eight states and then lets the timers run out. That behaviour covers the exact per-state legality table, the choice between the recovery variants, and the exact edge on which each timed state is left, including the delay an illegal command adds.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESELECT  = 4'd0,
    CMD_NOP       = 4'd1,
    CMD_BURSTSTOP = 4'd2,
    CMD_READ      = 4'd3,
    CMD_WRITE     = 4'd4,
    CMD_ACTIVATE  = 4'd5,
    CMD_PRECHARGE = 4'd6,
    CMD_REFRESH   = 4'd7,
    CMD_MODESET   = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ROWOPEN = 3'd1,
    ST_WRRCV   = 3'd2,
    ST_WRRCVAP = 3'd3,
    ST_PRECHG  = 3'd4,
    ST_REFRESH = 3'd5,
    ST_MODESET = 3'd6,
    ST_PWRDN   = 3'd7
  } state_e;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic ldDpl;
    logic ldRc;
    logic ldRsc;
    logic ldRp;
    logic hold;
  } tmrStrobe_t;

  function automatic cmd_e decodeCmd(input logic csN, input logic rasN,
                                     input logic casN, input logic weN);
    if (csN) return CMD_DESELECT;
    case ({rasN, casN, weN})
      3'b111:  return CMD_NOP;
      3'b110:  return CMD_BURSTSTOP;
      3'b101:  return CMD_READ;
      3'b100:  return CMD_WRITE;
      3'b011:  return CMD_ACTIVATE;
      3'b010:  return CMD_PRECHARGE;
      3'b001:  return CMD_REFRESH;
      default: return CMD_MODESET;
    endcase
  endfunction

endpackage

// File: rtl/sdram_mon_timer.sv
module sdram_mon_timer
  import sdram_mon_pkg::*;
#(
  parameter int TDPL = 2,
  parameter int TRC  = 8,
  parameter int TRSC = 2,
  parameter int TRP  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrStrobe_t stb,
  output logic       expired
);

  localparam int MAXA = (TDPL > TRC) ? TDPL : TRC;
  localparam int MAXB = (TRSC > TRP) ? TRSC : TRP;
  localparam int MAXT = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic          anyLd;

  assign anyLd   = stb.ldDpl | stb.ldRc | stb.ldRsc | stb.ldRp;
  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cnt <= '0;
    else if (stb.ldDpl)               cnt <= CW'(TDPL - 1);
    else if (stb.ldRc)                cnt <= CW'(TRC - 1);
    else if (stb.ldRsc)               cnt <= CW'(TRSC - 1);
    else if (stb.ldRp)                cnt <= CW'(TRP - 1);
    else if (!stb.hold && cnt != '0)  cnt <= cnt - CW'(1);
  end

  AST_HOLD_FREEZES_CNT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.hold) && !$past(anyLd)) |-> $stable(cnt)); // R12

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(MAXT - 1)); // R11

endmodule

// File: rtl/sdram_mon_ctrl.sv
module sdram_mon_ctrl
  import sdram_mon_pkg::*;
#(
  parameter int BA_W       = 2,
  parameter int TRACK_BANK = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic            a10,
  input  logic [BA_W-1:0] ba,
  input  logic            cke,
  input  logic            expired,
  output tmrStrobe_t      stb,
  output cmd_e            cmdQ,
  output state_e          stateQ,
  output logic            illegalQ
);

  cmd_e   cmdNow;
  state_e stNext;
  logic   ownBank, bankCmd, quiet, passive, ill;

  always_comb begin
    cmdNow  = decodeCmd(csN, rasN, casN, weN);
    ownBank = (ba == BA_W'(TRACK_BANK));
    bankCmd = (cmdNow == CMD_READ) || (cmdNow == CMD_WRITE) ||
              (cmdNow == CMD_ACTIVATE) || ((cmdNow == CMD_PRECHARGE) && !a10);
    quiet   = (cmdNow == CMD_DESELECT) || (cmdNow == CMD_NOP) ||
              (cmdNow == CMD_BURSTSTOP);
    passive = quiet || (bankCmd && !ownBank);
    stNext  = stateQ;
    ill     = 1'b0;
    stb     = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (!cke) stNext = ST_PWRDN;
        else if (passive || cmdNow == CMD_PRECHARGE) stNext = ST_IDLE;
        else if (cmdNow == CMD_ACTIVATE) stNext = ST_ROWOPEN;
        else if (cmdNow == CMD_REFRESH) begin stNext = ST_REFRESH; stb.ldRc = 1'b1; end
        else if (cmdNow == CMD_MODESET) begin stNext = ST_MODESET; stb.ldRsc = 1'b1; end
        else ill = 1'b1;
      end
      ST_ROWOPEN, ST_WRRCV: begin
        if (passive) begin
          if (stateQ == ST_WRRCV && expired) stNext = ST_ROWOPEN;
        end else if (cmdNow == CMD_READ) begin
          if (a10) begin stNext = ST_PRECHG; stb.ldRp = 1'b1; end
          else stNext = ST_ROWOPEN;
        end else if (cmdNow == CMD_WRITE) begin
          stNext    = a10 ? ST_WRRCVAP : ST_WRRCV;
          stb.ldDpl = 1'b1;
        end else if (cmdNow == CMD_PRECHARGE && stateQ == ST_ROWOPEN) begin
          stNext   = ST_PRECHG;
          stb.ldRp = 1'b1;
        end else ill = 1'b1;
      end
      ST_WRRCVAP: begin
        if (passive) begin
          if (expired) begin stNext = ST_PRECHG; stb.ldRp = 1'b1; end
        end else ill = 1'b1;
      end
      ST_PRECHG: begin
        if (passive || cmdNow == CMD_PRECHARGE) begin
          if (expired) stNext = ST_IDLE;
        end else ill = 1'b1;
      end
      ST_REFRESH: begin
        if (quiet) begin
          if (expired) stNext = ST_IDLE;
        end else ill = 1'b1;
      end
      ST_MODESET: begin
        if (cmdNow == CMD_DESELECT || cmdNow == CMD_NOP) begin
          if (expired) stNext = ST_IDLE;
        end else ill = 1'b1;
      end
      default: begin
        if (cke) stNext = ST_IDLE;
      end
    endcase
    if (ill) stNext = stateQ;
    stb.hold = ill;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ     <= CMD_DESELECT;
      stateQ   <= ST_IDLE;
      illegalQ <= 1'b0;
    end else begin
      cmdQ     <= cmdNow;
      stateQ   <= stNext;
      illegalQ <= ill;
    end
  end

  AST_ILLEGAL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    illegalQ |-> (stateQ == $past(stateQ))); // R12

  AST_PWRDN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PWRDN && $past(stateQ) != ST_PWRDN) |-> ($past(stateQ) == ST_IDLE)); // R3

  AST_PWRDN_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_PWRDN) |-> !illegalQ); // R4

  AST_REFRESH_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_REFRESH && stateQ != ST_REFRESH) |-> (stateQ == ST_IDLE)); // R8

  AST_MODESET_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_MODESET && stateQ != ST_MODESET) |-> (stateQ == ST_IDLE)); // R9

  AST_APRCV_TO_PRECHG: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_WRRCVAP && stateQ != ST_WRRCVAP) |-> (stateQ == ST_PRECHG)); // R7

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W       = 2,
  parameter int TRACK_BANK = 0,
  parameter int TDPL       = 2,
  parameter int TRC        = 8,
  parameter int TRSC       = 2,
  parameter int TRP        = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic            a10,
  input  logic [BA_W-1:0] ba,
  input  logic            cke,
  output logic [3:0]      cmdOut,
  output logic [2:0]      stateOut,
  output logic            illegal
);

  tmrStrobe_t stb;
  logic       expired;
  cmd_e       cmdQ;
  state_e     stateQ;

  sdram_mon_ctrl #(.BA_W(BA_W), .TRACK_BANK(TRACK_BANK)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .a10(a10), .ba(ba), .cke(cke), .expired(expired), .stb(stb),
    .cmdQ(cmdQ), .stateQ(stateQ), .illegalQ(illegal)
  );

  sdram_mon_timer #(.TDPL(TDPL), .TRC(TRC), .TRSC(TRSC), .TRP(TRP)) u_timer (
    .clk(clk), .rstN(rstN), .stb(stb), .expired(expired)
  );

  assign cmdOut   = cmdQ;
  assign stateOut = stateQ;

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BA_W = 2;
  localparam int TDPL = 2;
  localparam int TRC  = 3;
  localparam int TRSC = 2;
  localparam int TRP  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic a10 = 1'b0, cke = 1'b1;
  logic [BA_W-1:0] ba = '0;
  logic [3:0] cmdOut;
  logic [2:0] stateOut;
  logic illegal;

  int checks = 0;
  int errors = 0;
  int mState = 0;
  int mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor #(.BA_W(BA_W), .TRACK_BANK(0), .TDPL(TDPL), .TRC(TRC),
                      .TRSC(TRSC), .TRP(TRP)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .a10(a10), .ba(ba), .cke(cke), .cmdOut(cmdOut), .stateOut(stateOut),
    .illegal(illegal)
  );

  function automatic logic [3:0] pinsOf(int c);
    case (c)
      0: return 4'b1111; 1: return 4'b0111; 2: return 4'b0110;
      3: return 4'b0101; 4: return 4'b0100; 5: return 4'b0011;
      6: return 4'b0010; 7: return 4'b0001; default: return 4'b0000;
    endcase
  endfunction

  function automatic string stTag(int s);
    case (s)
      0: return "R3"; 1: return "R5"; 2: return "R6"; 3: return "R7";
      4: return "R10"; 5: return "R8"; 6: return "R9"; default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(int c, bit a10v, bit foreign, bit ckev);
    int nS, nC, target, reload;
    bit ill, quiet, bankc, passive, tick;
    string tag;
    {csN, rasN, casN, weN} = pinsOf(c);
    a10 = a10v; cke = ckev; ba = foreign ? BA_W'(1) : BA_W'(0);
    quiet   = (c <= 2);
    bankc   = (c == 3) || (c == 4) || (c == 5) || (c == 6 && !a10v);
    passive = quiet || (bankc && foreign);
    nS = mState; nC = mCnt; ill = 0; tick = 0; target = 0; reload = 0;
    tag = stTag(mState);
    case (mState)
      0: if (!ckev) nS = 7;
         else if (passive || c == 6) nS = 0;
         else if (c == 5) nS = 1;
         else if (c == 7) begin nS = 5; nC = TRC; end
         else if (c == 8) begin nS = 6; nC = TRSC; end
         else ill = 1;
      1, 2: if (passive) begin
              if (mState == 2) begin tick = 1; target = 1; end
            end
            else if (c == 3) begin
              if (a10v) begin nS = 4; nC = TRP; end else nS = 1;
            end
            else if (c == 4) begin nS = a10v ? 3 : 2; nC = TDPL; end
            else if (c == 6 && mState == 1) begin nS = 4; nC = TRP; end
            else ill = 1;
      3: if (passive) begin tick = 1; target = 4; reload = TRP; end else ill = 1;
      4: if (passive || c == 6) begin tick = 1; target = 0; end else ill = 1;
      5: if (quiet) begin tick = 1; target = 0; end else ill = 1;
      6: if (c <= 1) begin tick = 1; target = 0; end else ill = 1;
      default: if (ckev) nS = 0;
    endcase
    if (tick) begin
      nC = mCnt - 1;
      if (nC == 0) begin nS = target; nC = reload; tag = "R11"; end
    end
    if (ill) tag = "R12";
    else if (bankc && foreign && passive && mState <= 4) tag = "R13";
    @(posedge clk);
    mState = nS; mCnt = nC;
    @(negedge clk);
    check("R1", int'(cmdOut), c, "command");
    check(tag, int'(stateOut), mState, "state");
    check(tag, int'(illegal), int'(ill), "illegal");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; {csN, rasN, casN, weN} = 4'b1111; cke = 1'b1; a10 = 1'b0; ba = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mState = 0; mCnt = 0;
    check("R2", int'(stateOut), 0, "reset state");
    check("R2", int'(illegal), 0, "reset illegal");
    check("R2", int'(cmdOut), 0, "reset command");
  endtask

  task automatic gotoState(int s);
    case (s)
      1: step(5, 0, 0, 1);
      2: begin step(5, 0, 0, 1); step(4, 0, 0, 1); end
      3: begin step(5, 0, 0, 1); step(4, 1, 0, 1); end
      4: begin step(5, 0, 0, 1); step(6, 0, 0, 1); end
      5: step(7, 0, 0, 1);
      6: step(8, 0, 0, 1);
      7: step(1, 0, 0, 0);
      default: ;
    endcase
  endtask

  initial begin
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 9; c++)
        for (int a = 0; a < 2; a++)
          for (int f = 0; f < 2; f++) begin
            doReset();
            gotoState(s);
            step(c, a[0], f[0], (s == 7) ? 1'b0 : 1'b1);
            if (s == 7) step(1, 0, 0, 1);
            repeat (4) step(1, 0, 0, 1);
          end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule